// File: doc/BRIEF.md
# Start/Done Accumulate-and-Sum Core

This core adds two unsigned operands and, in the same operation, folds a third value into that sum. The third value behaves like a read-modify-write argument. It enters on its own input port and leaves, updated, on a separate output port. The operation is framed by a four-signal block handshake:

- a start request;
- an idle indicator;
- a completion pulse;
- a ready pulse.

The two operands, the incoming accumulate value and the plain sum result carry no qualifier of their own. The updated accumulate output is the only data port with a valid strobe.

A caller raises the start request while the core reports idle. The core samples all three data inputs on that clock edge. In the next cycle it presents both results, with completion, ready and the accumulate valid strobe high together for exactly one cycle. It then returns to idle. No back-pressure exists: the completion cycle is not stretched. A consumer must take the results in that cycle, so a new operation can begin at most every second cycle.

Top module: `sum_handshake_core`

## Requirements
- R1: `idle_o` is 1 whenever no operation is in progress. It is 0 exactly in the one cycle after a start is accepted.
- R2: A start is accepted only on a clock edge where `start_i` is 1 and `idle_o` is 1. A `start_i` that is high during the completion cycle is ignored, and the core is idle with no strobe in the cycle that follows.
- R3: `done_o` and `ready_o` are always equal. They are 1 for exactly one cycle, the cycle right after an accepted start.
- R4: In the completion cycle, `ret_o` equals `op_a_i + op_b_i` as sampled at the accepting edge, with the operands zero-extended to RES_W bits.
- R5: In the completion cycle, `acc_o` equals `op_a_i + op_b_i + acc_i` as sampled at the accepting edge.
- R6: `acc_vld_o` is a one-cycle pulse that coincides with `done_o`. It is never 1 at any other time.
- R7: A synchronous active-high `rst` returns the core to idle with `done_o`, `ready_o` and `acc_vld_o` at 0. This holds even if reset arrives in the middle of an operation.
- R8: Both sums wrap modulo 2^RES_W. Any carry out of the top bit is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| idle_o | output | 1 | No operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ready_o | output | 1 | One-cycle pulse: new inputs may be offered |
| op_a_i | input | OP_W | First operand, no qualifier |
| op_b_i | input | OP_W | Second operand, no qualifier |
| acc_i | input | RES_W | Incoming accumulate value, no qualifier |
| ret_o | output | RES_W | Plain sum result, valid in the completion cycle |
| acc_o | output | RES_W | Updated accumulate value |
| acc_vld_o | output | 1 | One-cycle valid strobe for `acc_o` |

## Verification
The assertions assume that `start_i` and the three data inputs hold known values at every sampled edge. They also assume the caller treats results as meaningful only in the completion cycle, because only that cycle is checked against the sampled operands. The bench changes inputs on the falling edge, so no input is in motion at a rising edge. It sweeps every operand pair and every accumulate value of a 3-bit/4-bit configuration, which reaches all wrap cases. It also covers a start held through the completion cycle and a reset during an operation.

// File: rtl/sum_core_pkg.sv
package sum_core_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } core_state_e;
endpackage

// File: rtl/sum_core_ctrl.sv
module sum_core_ctrl
  import sum_core_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic capture_o,
  output logic idle_o,
  output logic done_o
);
  core_state_e state_q, state_d;

  // Accept a start only while idle.
  assign capture_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign done_o = (state_q == ST_RUN);

  assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_accept_then_done_R3: assert property (@(posedge clk) disable iff (rst)
    capture_o |=> (done_o && !idle_o));
  assert_no_accept_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !idle_o |-> !capture_o);
  assert_idle_excl_done_R1: assert property (@(posedge clk) disable iff (rst)
    idle_o != done_o);
endmodule

// File: rtl/sum_core_adders.sv
module sum_core_adders #(
  parameter int OP_W  = 16,
  parameter int RES_W = 16
) (
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic [RES_W-1:0] acc_in,
  output logic [RES_W-1:0] ret_sum,
  output logic [RES_W-1:0] acc_sum
);
  logic [RES_W-1:0] a_ext, b_ext;

  generate
    if (RES_W > OP_W) begin : g_widen
      localparam int PAD = RES_W - OP_W;
      assign a_ext = {{PAD{1'b0}}, op_a};
      assign b_ext = {{PAD{1'b0}}, op_b};
    end else begin : g_trim
      assign a_ext = op_a[RES_W-1:0];
      assign b_ext = op_b[RES_W-1:0];
    end
  endgenerate

  // Both sums wrap at RES_W bits.
  assign ret_sum = a_ext + b_ext;
  assign acc_sum = ret_sum + acc_in;
endmodule

// File: rtl/sum_core_regs.sv
module sum_core_regs #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] ret_d,
  input  logic [RES_W-1:0] acc_d,
  output logic [RES_W-1:0] ret_q,
  output logic [RES_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ret_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      ret_q <= ret_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/sum_handshake_core.sv
module sum_handshake_core #(
  parameter int OP_W  = 16,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             idle_o,
  output logic             done_o,
  output logic             ready_o,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic [RES_W-1:0] acc_i,
  output logic [RES_W-1:0] ret_o,
  output logic [RES_W-1:0] acc_o,
  output logic             acc_vld_o
);
  logic             capture;
  logic             done_int;
  logic [RES_W-1:0] ret_sum, acc_sum;

  sum_core_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .capture_o (capture),
    .idle_o    (idle_o),
    .done_o    (done_int)
  );

  sum_core_adders #(.OP_W(OP_W), .RES_W(RES_W)) u_add (
    .op_a    (op_a_i),
    .op_b    (op_b_i),
    .acc_in  (acc_i),
    .ret_sum (ret_sum),
    .acc_sum (acc_sum)
  );

  sum_core_regs #(.RES_W(RES_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .load  (capture),
    .ret_d (ret_sum),
    .acc_d (acc_sum),
    .ret_q (ret_o),
    .acc_q (acc_o)
  );

  assign done_o    = done_int;
  assign ready_o   = done_int;
  assign acc_vld_o = done_int;

  // Reference sums built from the ports.
  logic [RES_W-1:0] chk_ret, chk_acc;
  assign chk_ret = RES_W'(op_a_i) + RES_W'(op_b_i);
  assign chk_acc = RES_W'(op_a_i) + RES_W'(op_b_i) + acc_i;

  assert_ret_value_R4: assert property (@(posedge clk) disable iff (rst)
    (start_i && idle_o) |=> (ret_o == $past(chk_ret)));
  assert_acc_value_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && idle_o) |=> (acc_o == $past(chk_acc)));
  assert_vld_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    acc_vld_o == (done_o && ready_o));
  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (idle_o && !acc_vld_o));
endmodule

// File: tb/sim_sum_handshake_core.sv
`timescale 1ns/1ps
module sim_sum_handshake_core;
  localparam int OP_W  = 3;
  localparam int RES_W = 4;
  localparam int MOD   = 1 << RES_W;

  logic clk = 1'b0;
  logic rst, start_i;
  logic idle_o, done_o, ready_o, acc_vld_o;
  logic [OP_W-1:0]  op_a_i, op_b_i;
  logic [RES_W-1:0] acc_i, ret_o, acc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sum_handshake_core #(.OP_W(OP_W), .RES_W(RES_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .idle_o(idle_o), .done_o(done_o), .ready_o(ready_o),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .acc_i(acc_i),
    .ret_o(ret_o), .acc_o(acc_o), .acc_vld_o(acc_vld_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobes all low, idle high.
  task automatic chk_quiet(input string req);
    chk({req, " idle"}, int'(idle_o), 1);
    chk({req, " done"}, int'(done_o), 0);
    chk({req, " ready"}, int'(ready_o), 0);
    chk({req, " vld"}, int'(acc_vld_o), 0);
  endtask

  task automatic run_op(input int a, input int b, input int c);
    @(negedge clk);
    start_i = 1'b1;
    op_a_i = OP_W'(a);
    op_b_i = OP_W'(b);
    acc_i = RES_W'(c);
    @(posedge clk); #1;
    chk("R1 busy idle", int'(idle_o), 0);
    chk("R3 done", int'(done_o), 1);
    chk("R3 ready", int'(ready_o), 1);
    chk("R6 vld", int'(acc_vld_o), 1);
    chk("R4 R8 ret", int'(ret_o), (a + b) % MOD);
    chk("R5 R8 acc", int'(acc_o), (a + b + c) % MOD);
    @(negedge clk);
    start_i = 1'b0;
    op_a_i = ~op_a_i;
    acc_i = ~acc_i;
    @(posedge clk); #1;
    chk_quiet("R3 R6 after");
  endtask

  initial begin
    rst = 1'b1;
    start_i = 1'b0;
    op_a_i = '0;
    op_b_i = '0;
    acc_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk_quiet("R7 reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk_quiet("R1 idle at rest");

    // R4 R5 R8: exhaustive sweep.
    for (int a = 0; a < (1 << OP_W); a++)
      for (int b = 0; b < (1 << OP_W); b++)
        for (int c = 0; c < MOD; c++)
          run_op(a, b, c);

    // R2: start held through the completion cycle, with new operands.
    @(negedge clk);
    start_i = 1'b1;
    op_a_i = 3'd5;
    op_b_i = 3'd6;
    acc_i = 4'd9;
    @(posedge clk); #1;
    chk("R2 first ret", int'(ret_o), 11);
    chk("R2 first acc", int'(acc_o), (5 + 6 + 9) % MOD);
    @(negedge clk);
    op_a_i = 3'd1;
    op_b_i = 3'd1;
    acc_i = 4'd1;
    @(posedge clk); #1;
    chk_quiet("R2 busy start ignored");
    chk("R2 ret kept", int'(ret_o), 11);
    @(negedge clk);
    start_i = 1'b0;
    @(posedge clk); #1;
    chk_quiet("R2 no second op");

    // R7: reset in the middle of an operation.
    @(negedge clk);
    start_i = 1'b1;
    op_a_i = 3'd2;
    @(posedge clk); #1;
    chk("R7 pre done", int'(done_o), 1);
    @(negedge clk);
    start_i = 1'b0;
    rst = 1'b1;
    @(posedge clk); #1;
    chk_quiet("R7 mid reset");
    @(negedge clk);
    rst = 1'b0;
    run_op(7, 7, 15);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule